// File: doc/BRIEF.md
# Parallel ADC read controller

This block sequences a 12-bit successive-approximation converter that shares an 8-bit parallel read bus. On a start request it pulls the read/convert line low, then asserts chip select for a timed convert pulse. It waits for the converter's busy line to fall and then rise again, and reads the finished result in two byte transfers steered by a byte-select line. The two bytes are put back together into one 12-bit sample, which is presented with a single-cycle valid strobe.

Every analog-side limit is a parameter given in nanoseconds. Each one is turned into clock cycles by rounding up. These limits are the convert pulse, the setup of read/convert ahead of chip select, the bus access time, the minimum spacing between conversion starts and the busy timeout. A conversion whose busy handshake never completes ends with a one-cycle timeout pulse instead of a sample. The host sees `start_ready` and may only start a conversion while it is high.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `adc_rc_n` and `adc_cs_n` are high, `adc_byte` is low, and `sample_valid`, `timeout_pulse` and `sample` are zero. `start_ready` is high from the first cycle after reset is released.
- R2: A start request is taken only in a cycle where `start_ready` is high. `start_ready` is low while a conversion or read is in progress and while the spacing window is running. A request raised while `start_ready` is low is not stored and starts no conversion.
- R3: After a request is accepted, `adc_rc_n` goes low with `adc_cs_n` still high for the setup time (2 cycles by default). Then both lines are low together for exactly the convert pulse length (8 cycles by default). Then both return high. `adc_rc_n` never changes in a cycle where `adc_cs_n` falls.
- R4: Falling edges of `adc_rc_n` are at least the spacing time apart (2000 cycles by default). If the request is held high, the gap is exactly that value.
- R5: The bus is enabled for reading (`adc_cs_n` low with `adc_rc_n` high) only after the synchronised busy line has been seen low and then high again after the convert pulse.
- R6: The first transfer has `adc_byte` = 0 and takes result bits 11..4 from `adc_data[7:0]`. The second has `adc_byte` = 1 and takes result bits 3..0 from `adc_data[7:4]`. `adc_data[3:0]` is ignored in that transfer.
- R7: `sample_valid` is high for exactly one cycle per completed conversion, in the cycle after the second transfer ends. `sample` then holds the assembled value until the next completed conversion.
- R8: If busy has not gone low and then high within the timeout (2400 cycles by default) after the convert pulse ends, `timeout_pulse` is high for one cycle. This is the cycle after the timeout, which is setup + pulse + timeout cycles after the `adc_rc_n` falling edge. No `sample_valid` follows, `sample` keeps its previous value, and the block returns to idle.
- R9: Each limit in nanoseconds is rounded up to whole clock cycles. At a 5 ns clock, the 83 ns access time becomes 17 cycles. Each byte transfer holds `adc_byte` steady with the bus enabled for 17 + 1 = 18 cycles and samples the bus at the end of the last of them. One read therefore enables the bus for 36 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to start a conversion |
| start_ready | output | 1 | Idle and spacing window elapsed; a request is taken now |
| adc_rc_n | output | 1 | Read/convert line to converter: low converts, high reads |
| adc_cs_n | output | 1 | Active-low chip select to converter |
| adc_byte | output | 1 | Byte select: 0 high byte, 1 low nibble |
| adc_busy | input | 1 | Converter busy line, low while converting (asynchronous) |
| adc_data | input | LANE_W (8) | Converter parallel read lane |
| sample | output | RES_W (12) | Last assembled conversion result |
| sample_valid | output | 1 | One-cycle strobe for a new `sample` |
| timeout_pulse | output | 1 | One-cycle flag for a conversion abandoned on timeout |

## Verification
Two functions can land in the same cycle: the spacing window expiring and a new request being accepted. A held request is accepted in the very cycle the window closes. The bench provokes this by keeping `start_req` high across two back-to-back conversions. It judges the result by requiring the gap between the two read/convert falling edges to equal the spacing count exactly, and both queued samples to arrive intact. The bench's converter model drives a poison byte on the bus until the access time has fully elapsed. Any early sampling, or any read made before the busy handshake, therefore shows up as a wrong sample value at the scoreboard.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the parallel ADC read controller.
// Assumes: times are given as integer nanoseconds, the clock as picoseconds.
package adc_rd_pkg;

    // Sequencer states, in the order a normal conversion walks them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSETUP,
        ST_CPULSE,
        ST_WAITB,
        ST_RSETUP,
        ST_RHI,
        ST_RLO,
        ST_EMIT
    } rd_state_t;

    // Rounds a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
        int c;
        c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
`timescale 1ns/1ps
// Loadable down-counter. After a load of N, done is high N cycles later.
// Assumes: load wins over counting; done holds until the next load.
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count down towards zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a single asynchronous level.
// Assumes: STAGES >= 1; the reset value is the line's idle level.
module adc_rd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_chain
            // Shift the level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_assemble.sv
`timescale 1ns/1ps
// Rebuilds a result wider than one bus lane from two transfers.
// The first transfer carries the top LANE_W bits. The second carries the
// remaining low bits left-aligned in the lane.
// Assumes: LANE_W < RES_W <= 2*LANE_W; cap_hi precedes cap_lo.
module adc_rd_assemble #(
    parameter int RES_W  = 12,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] lane,
    input  logic              cap_hi,
    input  logic              cap_lo,
    output logic [RES_W-1:0]  sample
);
    localparam int LOW_W = RES_W - LANE_W;

    logic [LANE_W-1:0] hi_q;
    logic [RES_W-1:0]  sample_q;
    logic [LOW_W-1:0]  lo_bits;

    // Low bits sit at the top of the lane during the second transfer.
    assign lo_bits = lane[LANE_W-1 -: LOW_W];

    // Hold the first transfer until the second arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (cap_hi) hi_q <= lane;
    end

    // Publish the full word once the second transfer is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)      sample_q <= '0;
        else if (cap_lo) sample_q <= {hi_q, lo_bits};
    end

    assign sample = sample_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
// Host-side sequencer for a 12-bit converter with an 8-bit parallel lane.
// It starts a conversion with a timed read/convert and chip-select pulse,
// waits for busy to fall and rise, reads two byte transfers, reassembles
// the sample and enforces the minimum spacing between starts.
// Assumes: busy is asynchronous and is synchronised here; adc_data is stable
// by the end of the access window, so it is captured directly.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_PS      = 5000,
    parameter int PULSE_NS    = 40,
    parameter int SETUP_NS    = 10,
    parameter int ACCESS_NS   = 83,
    parameter int SPACING_NS  = 10000,
    parameter int TIMEOUT_NS  = 12000,
    parameter int SYNC_STAGES = 2,
    parameter int RES_W       = 12,
    parameter int LANE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic              start_ready,
    output logic              adc_rc_n,
    output logic              adc_cs_n,
    output logic              adc_byte,
    input  logic              adc_busy,
    input  logic [LANE_W-1:0] adc_data,
    output logic [RES_W-1:0]  sample,
    output logic              sample_valid,
    output logic              timeout_pulse
);
    localparam int PULSE_CYC   = ns_to_cyc(PULSE_NS, CLK_PS);
    localparam int SETUP_CYC   = ns_to_cyc(SETUP_NS, CLK_PS);
    localparam int ACCESS_CYC  = ns_to_cyc(ACCESS_NS, CLK_PS);
    localparam int SPACE_CYC   = ns_to_cyc(SPACING_NS, CLK_PS);
    localparam int TIMEOUT_CYC = ns_to_cyc(TIMEOUT_NS, CLK_PS);
    localparam int PH_MAX_A    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int PH_MAX      = (PH_MAX_A > ACCESS_CYC + 1) ? PH_MAX_A : ACCESS_CYC + 1;
    localparam int PH_W        = $clog2(PH_MAX + 1);
    localparam int SP_W        = $clog2(SPACE_CYC + 1);
    localparam int TO_W        = $clog2(TIMEOUT_CYC + 1);

    rd_state_t        state_q, state_d;
    logic             ph_load, ph_done;
    logic [PH_W-1:0]  ph_val;
    logic             sp_load, sp_done;
    logic             to_load, to_done;
    logic             busy_s;
    logic             seen_low_q;
    logic             busy_cycle_done;
    logic             cap_hi, cap_lo;
    logic             to_pulse_q;

    // Bring the converter's busy line into the clock domain.
    adc_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_busy),
        .q     (busy_s)
    );

    // Times the setup, convert pulse and byte access phases.
    adc_rd_timer #(.W(PH_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    // Minimum distance between two conversion starts.
    adc_rd_timer #(.W(SP_W)) u_space_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sp_load),
        .load_val (SP_W'(SPACE_CYC - 1)),
        .done     (sp_done)
    );

    // Limit on the busy handshake.
    adc_rd_timer #(.W(TO_W)) u_tout_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (to_load),
        .load_val (TO_W'(TIMEOUT_CYC - 1)),
        .done     (to_done)
    );

    // Reassemble the two byte transfers into one sample.
    adc_rd_assemble #(.RES_W(RES_W), .LANE_W(LANE_W)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane   (adc_data),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .sample (sample)
    );

    assign busy_cycle_done = seen_low_q && busy_s;

    // Next-state, timer loads and capture strobes.
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        sp_load = 1'b0;
        to_load = 1'b0;
        cap_hi  = 1'b0;
        cap_lo  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && sp_done) begin
                    state_d = ST_CSETUP;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(SETUP_CYC - 1);
                    sp_load = 1'b1;
                end
            end
            ST_CSETUP: begin
                if (ph_done) begin
                    state_d = ST_CPULSE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(PULSE_CYC - 1);
                end
            end
            ST_CPULSE: begin
                if (ph_done) begin
                    state_d = ST_WAITB;
                    to_load = 1'b1;
                end
            end
            ST_WAITB: begin
                if (busy_cycle_done) begin
                    state_d = ST_RSETUP;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(SETUP_CYC - 1);
                end else if (to_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RSETUP: begin
                if (ph_done) begin
                    state_d = ST_RHI;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(ACCESS_CYC);
                end
            end
            ST_RHI: begin
                if (ph_done) begin
                    state_d = ST_RLO;
                    cap_hi  = 1'b1;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(ACCESS_CYC);
                end
            end
            ST_RLO: begin
                if (ph_done) begin
                    state_d = ST_EMIT;
                    cap_lo  = 1'b1;
                end
            end
            ST_EMIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remember that busy went low during this handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_low_q <= 1'b0;
        else if (state_q != ST_WAITB)
            seen_low_q <= 1'b0;
        else if (!busy_s)
            seen_low_q <= 1'b1;
    end

    // Flag an abandoned handshake for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_pulse_q <= 1'b0;
        else
            to_pulse_q <= (state_q == ST_WAITB) && !busy_cycle_done && to_done;
    end

    // Converter pins and host strobes decoded from the state.
    always_comb begin
        adc_rc_n      = !(state_q == ST_CSETUP || state_q == ST_CPULSE);
        adc_cs_n      = !(state_q == ST_CPULSE || state_q == ST_RHI || state_q == ST_RLO);
        adc_byte      = (state_q == ST_RLO);
        sample_valid  = (state_q == ST_EMIT);
        start_ready   = (state_q == ST_IDLE) && sp_done;
        timeout_pulse = to_pulse_q;
    end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for adc_rd_ctrl, attached by bind.
// Assumes: the converter pins are sampled on the controller clock.
module adc_rd_ctrl_chk #(
    parameter int PULSE_CYC = 8,
    parameter int SPACE_CYC = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic adc_rc_n,
    input logic adc_cs_n,
    input logic adc_byte,
    input logic busy_s,
    input logic sample_valid,
    input logic timeout_pulse
);
    logic conv_now;
    logic prev_conv, prev_rc, prev_cs, seen_fall;
    int   lowcnt, gapcnt;

    assign conv_now = !adc_rc_n && !adc_cs_n;

    // Track previous pin levels, pulse length and start spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_conv <= 1'b0;
            prev_rc   <= 1'b1;
            prev_cs   <= 1'b1;
            seen_fall <= 1'b0;
            lowcnt    <= 0;
            gapcnt    <= 0;
        end else begin
            prev_conv <= conv_now;
            prev_rc   <= adc_rc_n;
            prev_cs   <= adc_cs_n;
            lowcnt    <= conv_now ? lowcnt + 1 : 0;
            if (prev_rc && !adc_rc_n) begin
                seen_fall <= 1'b1;
                gapcnt    <= 1;
            end else if (gapcnt < SPACE_CYC) begin
                gapcnt <= gapcnt + 1;
            end
        end
    end

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_conv && !conv_now) |-> (lowcnt == PULSE_CYC));

    assert_cs_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_cs && !adc_cs_n) |-> (prev_rc == adc_rc_n));

    assert_start_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_rc && !adc_rc_n && seen_fall) |-> (gapcnt >= SPACE_CYC));

    assert_read_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && adc_rc_n) |-> busy_s);

    assert_byte_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_byte |-> (!adc_cs_n && adc_rc_n));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    assert_valid_vs_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> !timeout_pulse);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .PULSE_CYC (PULSE_CYC),
    .SPACE_CYC (SPACE_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .adc_rc_n      (adc_rc_n),
    .adc_cs_n      (adc_cs_n),
    .adc_byte      (adc_byte),
    .busy_s        (busy_s),
    .sample_valid  (sample_valid),
    .timeout_pulse (timeout_pulse)
);

// File: tb/adc_rd_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor pops
// and compares them. A behavioural converter model drives busy and data.
module adc_rd_ctrl_tb;
    localparam int SETUP    = 2;
    localparam int PULSE    = 8;
    localparam int ACC      = 17;
    localparam int SPACE    = 2000;
    localparam int TOUT     = 2400;
    localparam int BUSY_DLY = 10;
    localparam int CONV_CYC = 1500;

    typedef struct packed {
        logic        is_to;
        logic [11:0] code;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        start_ready, adc_rc_n, adc_cs_n, adc_byte;
    logic        adc_busy;
    logic [7:0]  adc_data;
    logic [11:0] sample;
    logic        sample_valid, timeout_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    adc_rd_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .start_ready   (start_ready),
        .adc_rc_n      (adc_rc_n),
        .adc_cs_n      (adc_cs_n),
        .adc_byte      (adc_byte),
        .adc_busy      (adc_busy),
        .adc_data      (adc_data),
        .sample        (sample),
        .sample_valid  (sample_valid),
        .timeout_pulse (timeout_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int          mode = 0;          // 0 normal, 1 busy never falls, 2 busy never rises
    int          conv_t = -1;
    logic        conv_prev = 1'b0;
    bit          conv_done = 1'b0;
    logic [11:0] out_reg = '0;
    logic [11:0] pend = '0;
    logic [11:0] code_q[$];
    logic [2:0]  key, prev_key = 3'b111;
    int          en_cnt = 0;

    assign key = {adc_cs_n, adc_rc_n, adc_byte};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        conv_prev <= !adc_rc_n && !adc_cs_n;
        if (!adc_rc_n && !adc_cs_n && !conv_prev) begin
            conv_t    <= 0;
            conv_done <= 1'b0;
            if (code_q.size() > 0) pend <= code_q.pop_front();
        end else if (conv_t >= 0 && conv_t < 100000) begin
            conv_t <= conv_t + 1;
        end
        if (mode == 0 && conv_t == BUSY_DLY + CONV_CYC - 1) begin
            out_reg   <= pend;
            conv_done <= 1'b1;
        end
        prev_key <= key;
        en_cnt   <= (key == prev_key) ? en_cnt + 1 : 1;
    end

    always_comb begin
        case (mode)
            0:       adc_busy = !(conv_t >= BUSY_DLY && conv_t < BUSY_DLY + CONV_CYC);
            1:       adc_busy = 1'b1;
            default: adc_busy = !(conv_t >= BUSY_DLY);
        endcase
    end

    // Poison byte until the access time has fully elapsed.
    always_comb begin
        if (!adc_cs_n && adc_rc_n && key == prev_key && en_cnt >= ACC)
            adc_data = adc_byte ? {out_reg[3:0], 4'b0000} : out_reg[11:4];
        else
            adc_data = 8'hA5;
    end

    // ---------------- monitors ----------------
    exp_t        exp_q[$];
    logic [11:0] last_good = '0;
    bit          prev_valid = 1'b0;
    logic        prev_rc = 1'b1, prev_cs = 1'b1;
    int          su_cnt = 0, pw_cnt = 0, rd_cnt = 0, by_cnt = 0;
    int          n_starts = 0, last_fall = -1, last_gap = 0;

    // Scoreboard compare of samples and timeouts (R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid)
                check(!sample_valid, "R7 valid width", sample_valid, 0);
            prev_valid = sample_valid;
            if (sample_valid || timeout_pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", sample, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_to) begin
                        check(timeout_pulse && !sample_valid, "R8 timeout kind",
                              {timeout_pulse, sample_valid}, 2);
                        check(sample == last_good, "R8 sample held", sample, last_good);
                        check(cyc - last_fall == SETUP + PULSE + TOUT, "R8 timeout time",
                              cyc - last_fall, SETUP + PULSE + TOUT);
                    end else begin
                        check(sample_valid && sample == e.code, "R7 R6 sample", sample, e.code);
                        last_good = e.code;
                    end
                end
            end
        end
    end

    // Pin timing monitor (R3, R4, R5, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rc && !adc_rc_n) begin
                n_starts++;
                if (last_fall >= 0) last_gap = cyc - last_fall;
                last_fall = cyc;
            end
            if (!adc_rc_n && adc_cs_n) su_cnt++;
            if (!adc_rc_n && !adc_cs_n) begin
                if (pw_cnt == 0) check(su_cnt == SETUP, "R3 setup", su_cnt, SETUP);
                pw_cnt++;
            end else if (pw_cnt != 0) begin
                check(pw_cnt == PULSE, "R3 R9 pulse length", pw_cnt, PULSE);
                pw_cnt = 0;
                su_cnt = 0;
            end
            if (prev_cs && !adc_cs_n && adc_rc_n)
                check(adc_busy && conv_done, "R5 read after busy", {adc_busy, conv_done}, 3);
            if (!adc_cs_n && adc_rc_n) begin
                rd_cnt++;
                if (adc_byte) by_cnt++;
            end else if (rd_cnt != 0) begin
                check(rd_cnt == 2 * (ACC + 1), "R9 read window", rd_cnt, 2 * (ACC + 1));
                check(by_cnt == ACC + 1, "R6 low transfer", by_cnt, ACC + 1);
                rd_cnt = 0;
                by_cnt = 0;
            end
            prev_rc = adc_rc_n;
            prev_cs = adc_cs_n;
        end
    end

    // ---------------- driver ----------------
    task automatic wait_ready();
        while (!start_ready) @(negedge clk);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_conv(input logic [11:0] code);
        exp_t e;
        wait_ready();
        code_q.push_back(code);
        e.is_to = 1'b0;
        e.code  = code;
        exp_q.push_back(e);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic do_timeout(input int m);
        exp_t e;
        wait_ready();
        mode = m;
        e.is_to = 1'b1;
        e.code  = '0;
        exp_q.push_back(e);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        wait_drain();
        mode = 0;
    endtask

    initial begin
        int s0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(adc_rc_n && adc_cs_n && !adc_byte, "R1 pins", {adc_rc_n, adc_cs_n, adc_byte}, 6);
        check(!sample_valid && !timeout_pulse && sample == 0, "R1 outputs", sample, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_ready, "R1 ready after reset", start_ready, 1);

        // R6 R7: several codes
        do_conv(12'h000);
        do_conv(12'hFFF);
        do_conv(12'h800);
        do_conv(12'h7FF);
        do_conv(12'h3C6);
        do_conv(12'h9E1);
        wait_drain();

        // R2: requests while not ready are dropped
        s0 = n_starts;
        do_conv(12'h5B3);
        repeat (20) @(negedge clk);
        check(!start_ready, "R2 busy not ready", start_ready, 0);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        wait_drain();
        check(!start_ready, "R2 spacing not ready", start_ready, 0);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (SPACE) @(negedge clk);
        check(n_starts == s0 + 1, "R2 ignored requests", n_starts - s0, 1);

        // R4: held request, acceptance on spacing expiry
        wait_ready();
        s0 = n_starts;
        code_q.push_back(12'h1A7);
        code_q.push_back(12'hE38);
        exp_q.push_back('{1'b0, 12'h1A7});
        exp_q.push_back('{1'b0, 12'hE38});
        start_req = 1'b1;
        while (n_starts < s0 + 2) @(negedge clk);
        start_req = 1'b0;
        check(last_gap == SPACE, "R4 exact spacing", last_gap, SPACE);
        wait_drain();

        // R8: busy never falls, then busy never rises
        do_timeout(1);
        do_timeout(2);
        do_conv(12'h6D4);
        wait_drain();
        repeat (50) @(negedge clk);
        check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule